// File: doc/BRIEF.md
# Four-Channel Time-Slot Serial Voice Port

This block joins four voice channels to one shared serial highway that is divided into time slots. Each channel owns one transmit sync input and one receive sync input. A pulse on a channel's transmit sync places that channel's 8-bit word on the shared serial output, most significant bit first. The output enable is high only for those eight bit periods, and an active-low slot indicator is low for the same span. A pulse on a channel's receive sync makes the block gather the next eight serial input bits and hand them over as one parallel word, tagged with the channel number.

The bit clock is not a clock of the block. It is oversampled by the fast system clock, which must be at least four times faster. Every bit-clock input is expected to be synchronous to the system clock. A static pin selects the sync style. In short style, the sync is high for one bit period just before the slot. In long style, the sync rises at the slot's first bit and stays high for at least two bit periods. A per-channel standby input takes a channel out of all transfers. Companding and any analog function belong elsewhere.

Top module: `pcm_tdm_port`

## Requirements
- R1: In a transmit slot, the W bits of `tx_words[c*W +: W]` appear on `ser_out`, most significant bit first. The word is captured when the slot starts, and one new bit is launched on each rising edge of `bit_clk`.
- R2: `ser_oe` is high for exactly the W bit periods of a transmit slot and low at all other times. `ser_out` is 0 while `ser_oe` is low.
- R3: `slot_act_n` is low exactly while `ser_oe` is high.
- R4: With `long_sync`=0 (short style), a sync that is high for one bit period of channel c starts c's slot at the next rising edge of `bit_clk`.
- R5: With `long_sync`=1 (long style), a slot starts at the rising edge where the sync is first seen high. A sync that stays high does not start the slot again.
- R6: In a receive slot, `ser_in` is sampled on W falling edges of `bit_clk`, most significant bit first. One system clock after the last falling edge, `rx_valid` is high for one cycle, `rx_chan` holds c (0 to 3) and `rx_word` holds the word.
- R7: While `standby[c]`=1, the syncs of channel c are ignored: that channel never drives `ser_oe` and never produces `rx_valid`.
- R8: If several channels' transmit slots start on the same rising edge, the lowest-numbered channel is sent and `tx_collide` is high for one system cycle.
- R9: A transmit start during an unfinished slot abandons that slot and sends the new channel's word from its first bit. `tx_collide` is raised for one cycle.
- R10: After reset, `ser_oe`=0, `ser_out`=0, `slot_act_n`=1, `rx_valid`=0 and `tx_collide`=0.
- R11: Values on `ser_in` outside every receive slot have no effect on any received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, at least 4x the bit clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| bit_clk | input | 1 | highway bit clock, synchronous to clk |
| long_sync | input | 1 | 1 selects long sync style, 0 selects short |
| standby | input | NCH | per-channel standby, 1 excludes the channel |
| tx_sync | input | NCH | per-channel transmit sync |
| rx_sync | input | NCH | per-channel receive sync |
| tx_words | input | NCH*W | transmit words, channel c at bits c*W +: W |
| ser_in | input | 1 | serial receive data |
| ser_out | output | 1 | serial transmit data |
| ser_oe | output | 1 | drive enable for ser_out (high impedance when low) |
| slot_act_n | output | 1 | low while the block drives the highway |
| tx_collide | output | 1 | one-cycle pulse on overlapping transmit starts |
| rx_valid | output | 1 | one-cycle strobe for a received word |
| rx_chan | output | CW | channel of the received word |
| rx_word | output | W | received word |

## Verification
A bad bit counter or a bad shift register shows up at the ports within one bit period. It appears either as a wrong bit on `ser_out`, or as `ser_oe` staying high into the period after the slot. A bad sync history register shows up at the next slot, which starts one period early or late, or starts twice. On the receive side, a bad capture state gives a wrong word or a misplaced `rx_valid` at the end of the same slot. The sweeps check every bit period of every frame across both sync styles, all sixteen standby masks and three slot layouts, so any of these faults is reported within the frame where it first appears.

// File: rtl/pcm_hwy_pkg.sv
package pcm_hwy_pkg;
  localparam int unsigned DEF_NCH = 4;
  localparam int unsigned DEF_W   = 8;

  typedef enum logic {
    SYNC_SHORT = 1'b0,
    SYNC_LONG  = 1'b1
  } sync_style_e;
endpackage

// File: rtl/pcm_bclk_edge.sv
module pcm_bclk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_clk,
  output logic rise,
  output logic fall
);
  logic bclk_q, bclk_n;

  always_comb bclk_n = bit_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk_n;
  end

  assign rise = bit_clk & ~bclk_q;
  assign fall = ~bit_clk & bclk_q;
endmodule

// File: rtl/pcm_sync_detect.sv
module pcm_sync_detect #(
  parameter int unsigned NCH = pcm_hwy_pkg::DEF_NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rise,
  input  logic           long_sync,
  input  logic [NCH-1:0] sync_in,
  input  logic [NCH-1:0] standby,
  output logic [NCH-1:0] start
);
  import pcm_hwy_pkg::*;

  logic [NCH-1:0] seen1_q, seen2_q, seen1_n, seen2_n;
  sync_style_e    style;

  assign style = sync_style_e'(long_sync);

  always_comb begin
    seen1_n = seen1_q;
    seen2_n = seen2_q;
    if (rise) begin
      seen1_n = sync_in;
      seen2_n = seen1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen1_q <= '0;
      seen2_q <= '0;
    end else begin
      seen1_q <= seen1_n;
      seen2_q <= seen2_n;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic edge_long, edge_short;
    assign edge_long  = sync_in[g] & ~seen1_q[g];
    assign edge_short = seen1_q[g] & ~seen2_q[g];
    assign start[g]   = rise & ~standby[g] &
                        ((style == SYNC_LONG) ? edge_long : edge_short);
  end

  // R4/R5: a start only ever happens on a bit-clock rising edge, and never twice in a row
  assert_start_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|start) |=> !(|start));
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer #(
  parameter int unsigned NCH = pcm_hwy_pkg::DEF_NCH,
  parameter int unsigned W   = pcm_hwy_pkg::DEF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic [NCH-1:0]   start,
  input  logic [NCH*W-1:0] words,
  output logic             ser_out,
  output logic             ser_oe,
  output logic             collide
);
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned BW = $clog2(W);

  logic          act_q, act_n;
  logic [BW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  sh_q, sh_n;
  logic          col_q, col_n;
  logic [CW-1:0] win;
  logic [CW:0]   nstart;
  logic          any, multi, last;

  always_comb begin
    win    = '0;
    nstart = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (start[i]) win = CW'(i);
    end
    for (int i = 0; i < NCH; i++) begin
      nstart = nstart + {{CW{1'b0}}, start[i]};
    end
  end

  assign any   = |start;
  assign multi = (nstart > (CW+1)'(1));
  assign last  = (cnt_q == BW'(W - 1));

  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    sh_n  = sh_q;
    col_n = 1'b0;
    if (rise) begin
      if (any) begin
        sh_n  = words[win*W +: W];
        act_n = 1'b1;
        cnt_n = '0;
        col_n = multi | (act_q & ~last);
      end else if (act_q) begin
        if (last) begin
          act_n = 1'b0;
          cnt_n = '0;
        end else begin
          sh_n  = {sh_q[W-2:0], 1'b0};
          cnt_n = cnt_q + BW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
      col_q <= 1'b0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      col_q <= col_n;
    end
  end

  assign ser_out = act_q & sh_q[W-1];
  assign ser_oe  = act_q;
  assign collide = col_q;

  assert_collide_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    col_q |=> !col_q);
  assert_slot_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && act_q && last && !any) |=> !act_q);
  assert_oe_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(rise));
endmodule

// File: rtl/pcm_rx_deserializer.sv
module pcm_rx_deserializer #(
  parameter int unsigned NCH = pcm_hwy_pkg::DEF_NCH,
  parameter int unsigned W   = pcm_hwy_pkg::DEF_W
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 rise,
  input  logic                                 fall,
  input  logic [NCH-1:0]                       start,
  input  logic                                 ser_in,
  output logic                                 rx_valid,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] rx_chan,
  output logic [W-1:0]                         rx_word
);
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned BW = $clog2(W);

  logic [NCH-1:0]   done;
  logic [NCH*W-1:0] cand;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          act_q, act_n;
    logic [BW-1:0] cnt_q, cnt_n;
    logic [W-2:0]  sh_q, sh_n;
    logic          last;

    assign last = (cnt_q == BW'(W - 1));
    assign done[g] = fall & act_q & last;
    assign cand[g*W +: W] = {sh_q, ser_in};

    always_comb begin
      act_n = act_q;
      cnt_n = cnt_q;
      sh_n  = sh_q;
      if (rise && start[g]) begin
        act_n = 1'b1;
        cnt_n = '0;
      end else if (fall && act_q) begin
        sh_n = {sh_q[W-3:0], ser_in};
        if (last) begin
          act_n = 1'b0;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + BW'(1);
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= 1'b0;
        cnt_q <= '0;
        sh_q  <= '0;
      end else begin
        act_q <= act_n;
        cnt_q <= cnt_n;
        sh_q  <= sh_n;
      end
    end

    assert_rx_slot_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && act_q && last && !(rise && start[g])) |=> !act_q);
  end

  logic          v_q, v_n;
  logic [CW-1:0] ch_q, ch_n;
  logic [W-1:0]  w_q, w_n;

  always_comb begin
    v_n  = |done;
    ch_n = ch_q;
    w_n  = w_q;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (done[i]) begin
        ch_n = CW'(i);
        w_n  = cand[i*W +: W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      ch_q <= '0;
      w_q  <= '0;
    end else begin
      v_q  <= v_n;
      ch_q <= ch_n;
      w_q  <= w_n;
    end
  end

  assign rx_valid = v_q;
  assign rx_chan  = ch_q;
  assign rx_word  = w_q;

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |=> !v_q);
  assert_valid_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |-> $past(fall));
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port #(
  parameter int unsigned NCH = pcm_hwy_pkg::DEF_NCH,
  parameter int unsigned W   = pcm_hwy_pkg::DEF_W,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_clk,
  input  logic             long_sync,
  input  logic [NCH-1:0]   standby,
  input  logic [NCH-1:0]   tx_sync,
  input  logic [NCH-1:0]   rx_sync,
  input  logic [NCH*W-1:0] tx_words,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             ser_oe,
  output logic             slot_act_n,
  output logic             tx_collide,
  output logic             rx_valid,
  output logic [CW-1:0]    rx_chan,
  output logic [W-1:0]     rx_word
);
  logic [1:0]     rs_q;
  logic           core_rst_n;
  logic           rise, fall;
  logic [NCH-1:0] tx_start, rx_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  pcm_bclk_edge u_edge (
    .clk(clk), .rst_n(core_rst_n), .bit_clk(bit_clk), .rise(rise), .fall(fall)
  );

  pcm_sync_detect #(.NCH(NCH)) u_tx_sync (
    .clk(clk), .rst_n(core_rst_n), .rise(rise), .long_sync(long_sync),
    .sync_in(tx_sync), .standby(standby), .start(tx_start)
  );

  pcm_sync_detect #(.NCH(NCH)) u_rx_sync (
    .clk(clk), .rst_n(core_rst_n), .rise(rise), .long_sync(long_sync),
    .sync_in(rx_sync), .standby(standby), .start(rx_start)
  );

  pcm_tx_serializer #(.NCH(NCH), .W(W)) u_tx (
    .clk(clk), .rst_n(core_rst_n), .rise(rise), .start(tx_start),
    .words(tx_words), .ser_out(ser_out), .ser_oe(ser_oe), .collide(tx_collide)
  );

  pcm_rx_deserializer #(.NCH(NCH), .W(W)) u_rx (
    .clk(clk), .rst_n(core_rst_n), .rise(rise), .fall(fall), .start(rx_start),
    .ser_in(ser_in), .rx_valid(rx_valid), .rx_chan(rx_chan), .rx_word(rx_word)
  );

  assign slot_act_n = ~ser_oe;

  // R3: the indicator may fall only together with a rising bit-clock edge in the previous cycle
  assert_indicator_edge_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    $fell(slot_act_n) |-> $past(rise));
endmodule

// File: tb/pcm_tdm_port_tb.sv
module pcm_tdm_port_tb;
  localparam int NCH = 4;
  localparam int W   = 8;
  localparam int NP  = 48;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             bit_clk;
  logic             long_sync;
  logic [NCH-1:0]   standby;
  logic [NCH-1:0]   tx_sync;
  logic [NCH-1:0]   rx_sync;
  logic [NCH*W-1:0] tx_words;
  logic             ser_in;
  logic             ser_out, ser_oe, slot_act_n, tx_collide, rx_valid;
  logic [1:0]       rx_chan;
  logic [W-1:0]     rx_word;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic s_oe, s_bit, s_tsc, s_col, s_rv;
  logic [1:0] s_rc;
  logic [7:0] s_rw;

  always #5 clk = ~clk;

  pcm_tdm_port #(.NCH(NCH), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .long_sync(long_sync),
    .standby(standby), .tx_sync(tx_sync), .rx_sync(rx_sync), .tx_words(tx_words),
    .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe), .slot_act_n(slot_act_n),
    .tx_collide(tx_collide), .rx_valid(rx_valid), .rx_chan(rx_chan), .rx_word(rx_word)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] txw(input int c, input int salt);
    return 8'((c * 53 + salt * 29 + 8'h3A) ^ (salt >> 2));
  endfunction

  function automatic logic [7:0] rxw(input int c, input int salt);
    return 8'((c * 71 + salt * 17 + 8'hC5) ^ (salt * 3));
  endfunction

  // one bit period = 4 system clocks; outputs sampled away from posedge
  task automatic bit_period(input logic [3:0] fx, input logic [3:0] fr, input logic d);
    @(negedge clk);
    bit_clk = 1'b1; tx_sync = fx; rx_sync = fr; ser_in = d;
    @(negedge clk);
    s_oe = ser_oe; s_bit = ser_out; s_tsc = slot_act_n; s_col = tx_collide;
    @(negedge clk);
    bit_clk = 1'b0;
    @(negedge clk);
    s_rv = rx_valid; s_rc = rx_chan; s_rw = rx_word;
  endtask

  task automatic run_frame(input bit lng, input logic [3:0] pd, input int lay);
    int s[4];
    int ord[4];
    int gap;
    int salt;
    salt = lay * 32 + int'(pd) * 2 + int'(lng);
    case (lay)
      0: begin ord = '{0, 1, 2, 3}; gap = 0; end
      1: begin ord = '{3, 2, 1, 0}; gap = 1; end
      default: begin ord = '{2, 0, 3, 1}; gap = 3; end
    endcase
    for (int c = 0; c < 4; c++) s[c] = 2 + ord[c] * (8 + gap);
    long_sync = lng;
    standby = pd;
    for (int c = 0; c < 4; c++) tx_words[c*8 +: 8] = txw(c, salt);
    for (int p = 0; p < NP; p++) begin
      logic [3:0] fx;
      logic d, eoe, ebit, erv, dis_slot, dis_end;
      int erc;
      logic [7:0] erw;
      fx = '0; eoe = 0; ebit = 0; erv = 0; erc = 0; erw = '0;
      dis_slot = 0; dis_end = 0;
      d = ((p * 5 + lay) % 3) == 0;
      for (int c = 0; c < 4; c++) begin
        if (lng) fx[c] = (p == s[c]) || (p == s[c] + 1);
        else     fx[c] = (p == s[c] - 1);
        if (p >= s[c] && p < s[c] + 8) begin
          d = rxw(c, salt)[7 - (p - s[c])];
          if (pd[c]) dis_slot = 1;
          else begin
            eoe = 1;
            ebit = txw(c, salt)[7 - (p - s[c])];
          end
        end
        if (p == s[c] + 7) begin
          if (pd[c]) dis_end = 1;
          else begin erv = 1; erc = c; erw = rxw(c, salt); end
        end
      end
      bit_period(fx, fx, d);
      chk((dis_slot && !eoe) ? "R7 standby tx enable" : "R2 tx enable", s_oe, eoe);
      if (eoe) chk(lng ? "R1/R5 long tx bit" : "R1/R4 short tx bit", s_bit, ebit);
      else     chk("R2 idle ser_out", s_bit, 0);
      chk("R3 slot indicator", s_tsc, !eoe);
      chk("R8 no collide", s_col, 0);
      chk((dis_end && !erv) ? "R7 standby rx_valid" : "R6 rx_valid", s_rv, erv);
      if (erv) begin
        chk("R6 rx_chan", s_rc, erc);
        chk(lng ? "R6/R11/R5 rx_word" : "R6/R11/R4 rx_word", s_rw, erw);
      end
    end
  endtask

  task automatic run_collision();
    logic [7:0] w1, w3;
    w1 = 8'hB4; w3 = 8'h6D;
    long_sync = 1'b1;
    standby = 4'b0000;
    tx_words = {w3, 8'h99, w1, 8'h11};
    for (int p = 0; p < 16; p++) begin
      logic [3:0] fx;
      logic eoe, ebit, ecol;
      fx = '0;
      fx[1] = (p == 2 || p == 3);
      fx[2] = (p == 2 || p == 3);
      fx[3] = (p == 5 || p == 6);
      eoe = (p >= 2 && p <= 12);
      ebit = 0;
      if (p >= 2 && p <= 4)  ebit = w1[7 - (p - 2)];
      if (p >= 5 && p <= 12) ebit = w3[7 - (p - 5)];
      ecol = (p == 2 || p == 5);
      bit_period(fx, 4'b0000, 1'b0);
      chk(p == 5 ? "R9 collide on overlap" : "R8 collide on tie", s_col, ecol);
      chk("R2 enable during collision", s_oe, eoe);
      if (eoe) chk(p < 5 ? "R8 winner bit" : "R9 restarted bit", s_bit, ebit);
      chk("R3 indicator during collision", s_tsc, !eoe);
    end
    // the collision flag lasts a single system cycle
    @(negedge clk);
    bit_clk = 1'b1; tx_sync = 4'b0011;
    @(negedge clk);
    chk("R8 collide high", tx_collide, 1);
    @(negedge clk);
    chk("R8 collide one cycle", tx_collide, 0);
    bit_clk = 1'b0;
    @(negedge clk);
    tx_sync = 4'b0000;
    for (int p = 0; p < 10; p++) bit_period(4'b0000, 4'b0000, 1'b0);
    chk("R2 idle after collision tests", s_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_clk = 1'b0; long_sync = 1'b0; standby = '0;
    tx_sync = '0; rx_sync = '0; tx_words = '0; ser_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 reset ser_oe", ser_oe, 0);
    chk("R10 reset ser_out", ser_out, 0);
    chk("R10 reset slot_act_n", slot_act_n, 1);
    chk("R10 reset rx_valid", rx_valid, 0);
    chk("R10 reset tx_collide", tx_collide, 0);
    for (int m = 0; m < 2; m++)
      for (int pd = 0; pd < 16; pd++)
        for (int lay = 0; lay < 3; lay++)
          run_frame(m[0], 4'(pd), lay);
    run_collision();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule